// File: doc/BRIEF.md
# Receive Sync Character Hunt and Alignment

This block sits at the front of a synchronous serial receiver, ahead of the character assembler. It runs on the receive clock and samples one data bit on every rising edge. It tells the assembler where each character begins, using a one-cycle character-boundary strobe.

The block has four modes.

- **Monosync:** it hunts for one programmed 8-bit sync pattern.
- **Bisync:** it hunts for a 16-bit pattern that spans two consecutive characters.
- **External:** the sync pin is an input. A low level on it during the hunt sets the character alignment.
- **Async:** the sync pin is a plain status input. It does not affect alignment.

In both internal modes the sync pin is an output. It pulses low once each time the pattern is seen. The hunt ends on the first match, and an enter-hunt command restarts it. Whenever the pin is an input, every level change on it raises a one-cycle status interrupt pulse. This works the same way as on a modem control line.

Top module: `sync_hunt`

## Requirements
- R1: Each rising edge shifts `rx_data` into a history register, with the newest bit at position 0. In monosync mode (`mode`=1), a match means the last 8 received bits equal `sync_pat[7:0]`. While a match holds, `sync_out_n` is low for the cycle after the edge that received the last pattern bit.
- R2: In bisync mode (`mode`=2), a match needs all of the last 16 received bits to equal `sync_pat[15:0]`. Bits 15:8 are the character received first. Eight matching bits alone give no pulse.
- R3: `sync_oe` is 1 exactly when `mode` is 1 or 2. In async (`mode`=0) and external (`mode`=3) modes, `sync_out_n` stays high.
- R4: In an internal mode, the first match seen while `hunting` is 1 clears `hunting` at the next edge. Later matches still pulse `sync_out_n` but do not move the character alignment.
- R5: After a hunt ends, `char_start` is high for one cycle after every 8 received data bits. The first data bit is the one sampled on the edge after the pattern is seen. The first strobe therefore comes 8 cycles after the `sync_out_n` pulse. `char_start` is never high while `hunting` is 1.
- R6: In external mode, an edge that samples `sync_in_n` low while hunting ends the hunt. The bit sampled on the edge before it becomes the first bit of the character. The first `char_start` follows 6 edges after the sampling edge.
- R7: An edge that samples `enter_hunt` high sets `hunting` to 1 and restarts the bit count. This takes priority over any match or sync input on the same edge.
- R8: In async mode, `sync_status` shows the sync input level sampled on the last edge, with 1 meaning `sync_in_n` was low. The input does not change `hunting`, and `char_start` stays 0 in this mode.
- R9: In async and external modes, any change of the sampled `sync_in_n` level makes `sync_irq` high for exactly one cycle. This applies to both falling and rising changes.
- R10: After reset, `hunting` is 1 and `char_start`, `sync_status` and `sync_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; data sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 async, 1 monosync, 2 bisync, 3 external sync |
| sync_pat | input | 16 | Sync pattern; monosync uses bits 7:0 |
| enter_hunt | input | 1 | Restart the hunt (sampled on the edge) |
| rx_data | input | 1 | Serial receive data |
| sync_in_n | input | 1 | Sync pin input value, active low |
| sync_out_n | output | 1 | Sync pin output value, active low match pulse |
| sync_oe | output | 1 | Sync pin output enable |
| hunting | output | 1 | Hunt in progress |
| char_start | output | 1 | Character-boundary strobe to the assembler |
| sync_status | output | 1 | Sampled sync input level for status |
| sync_irq | output | 1 | One-cycle pulse on a sync input change |

## Verification
Each result has a fixed due cycle:

- A match pulse is due in the cycle right after the edge that receives the last pattern bit.
- The first boundary strobe comes 8 edges after the match pulse in the internal modes.
- In external mode, the first strobe comes 6 edges after the edge that samples the sync input low.
- Status, interrupt and hunt changes show one edge after the input that causes them.

Inputs are driven on the falling edge and outputs are sampled 1 ns after each rising edge. Each edge therefore has its own sample index. The bench compares the index of the first pulse or strobe, and the number of match pulses, against values worked out from these delays.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'd0,
        MODE_MONO  = 2'd1,
        MODE_BI    = 2'd2,
        MODE_EXT   = 2'd3
    } sh_mode_e;

endpackage

// File: rtl/sh_shift_cmp.sv
module sh_shift_cmp #(
    parameter int CHAR_W = 8,
    localparam int PAT_W = 2 * CHAR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_data,
    input  logic [PAT_W-1:0] pat,
    input  logic             wide,
    output logic             match
);

    typedef struct packed {
        logic [PAT_W-1:0] sr;
    } shc_t;

    shc_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sr = {st_q.sr[PAT_W-2:0], rx_data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (wide) match = (st_q.sr == pat);
        else      match = (st_q.sr[CHAR_W-1:0] == pat[CHAR_W-1:0]);
    end

    AST_MATCH_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && match) |-> ($past(rx_data) == pat[0])); // R1

endmodule

// File: rtl/sh_pin_monitor.sv
module sh_pin_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic sync_in_n,
    output logic status,
    output logic irq
);

    typedef struct packed {
        logic status;
        logic irq;
    } mon_t;

    mon_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (sample_en) begin
            st_d.status = ~sync_in_n;
            st_d.irq    = (~sync_in_n) != st_q.status;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;
    assign irq    = st_q.irq;

    AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && irq) |-> (status != $past(status))); // R9
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(status)); // R8

endmodule

// File: rtl/sync_hunt.sv
module sync_hunt #(
    parameter int CHAR_W = 8,
    localparam int PAT_W = 2 * CHAR_W,
    localparam int CNT_W = $clog2(CHAR_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [PAT_W-1:0] sync_pat,
    input  logic             enter_hunt,
    input  logic             rx_data,
    input  logic             sync_in_n,
    output logic             sync_out_n,
    output logic             sync_oe,
    output logic             hunting,
    output logic             char_start,
    output logic             sync_status,
    output logic             sync_irq
);
    import sync_hunt_pkg::*;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CHAR_W - 1);

    typedef struct packed {
        logic             hunting;
        logic [CNT_W-1:0] cnt;
        logic             char_start;
    } hunt_t;

    hunt_t st_d, st_q;
    sh_mode_e md;
    logic internal_m, ext_m, match;

    assign md         = sh_mode_e'(mode);
    assign internal_m = (md == MODE_MONO) || (md == MODE_BI);
    assign ext_m      = (md == MODE_EXT);

    sh_shift_cmp #(.CHAR_W(CHAR_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_data (rx_data),
        .pat     (sync_pat),
        .wide    (md == MODE_BI),
        .match   (match)
    );

    sh_pin_monitor u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (!internal_m),
        .sync_in_n (sync_in_n),
        .status    (sync_status),
        .irq       (sync_irq)
    );

    always_comb begin
        st_d            = st_q;
        st_d.char_start = 1'b0;
        if (enter_hunt) begin
            st_d.hunting = 1'b1;
            st_d.cnt     = '0;
        end else if (st_q.hunting) begin
            if (internal_m && match) begin
                st_d.hunting = 1'b0;
                st_d.cnt     = CNT_W'(1);
            end else if (ext_m && !sync_in_n) begin
                st_d.hunting = 1'b0;
                st_d.cnt     = CNT_W'(2);
            end
        end else if (md != MODE_ASYNC) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.cnt        = '0;
                st_d.char_start = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{hunting: 1'b1, cnt: '0, char_start: 1'b0};
        else        st_q <= st_d;
    end

    assign sync_oe    = internal_m;
    assign sync_out_n = ~(internal_m && match);
    assign hunting    = st_q.hunting;
    assign char_start = st_q.char_start;

    AST_HUNT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hunting && internal_m && match && !enter_hunt) |=> !hunting); // R4
    AST_EXT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (hunting && ext_m && !sync_in_n && !enter_hunt) |=> (st_q.cnt == CNT_W'(2))); // R6
    AST_ENTER_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        enter_hunt |=> (hunting && !char_start)); // R7
    AST_NO_CHAR_IN_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        hunting |-> !char_start); // R5
    AST_CHAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        char_start |=> !char_start); // R5

endmodule

// File: tb/sync_hunt_tb.sv
`timescale 1ns/1ps
module sync_hunt_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] sync_pat = 16'h0;
    logic        enter_hunt = 1'b0;
    logic        rx_data = 1'b0;
    logic        sync_in_n = 1'b1;
    logic        sync_out_n, sync_oe, hunting, char_start, sync_status, sync_irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    sync_hunt u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .sync_pat(sync_pat),
        .enter_hunt(enter_hunt), .rx_data(rx_data), .sync_in_n(sync_in_n),
        .sync_out_n(sync_out_n), .sync_oe(sync_oe), .hunting(hunting),
        .char_start(char_start), .sync_status(sync_status), .sync_irq(sync_irq)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] pat;
        logic [31:0] stream;
        logic [5:0]  sync_at;   // bit index where sync_in_n is low, 63 = never
        logic [2:0]  pulses;    // expected sync_out_n low cycles
        logic [5:0]  first_ch;  // expected first char_start index, 63 = none
        logic        hunt_end;  // expected hunting after the stream
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 16'h007E, 32'h007EA53C, 6'd63, 3'd1, 6'd23, 1'b0}, // R1 R5 monosync
        '{2'd2, 16'hA53C, 32'h0FA53C00, 6'd63, 3'd1, 6'd31, 1'b0}, // R2 R5 bisync
        '{2'd2, 16'hA53C, 32'hA5003C11, 6'd63, 3'd0, 6'd63, 1'b1}, // R2 split pattern
        '{2'd1, 16'h003C, 32'h3C003C00, 6'd63, 3'd2, 6'd15, 1'b0}, // R4 second match
        '{2'd0, 16'h003C, 32'h3C3C3C3C, 6'd63, 3'd0, 6'd63, 1'b1}, // R8 async
        '{2'd3, 16'h003C, 32'h3C3C3C3C, 6'd10, 3'd0, 6'd16, 1'b0}  // R6 external
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    int pulses_seen;
    int first_seen;

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        mode = v.mode; sync_pat = v.pat; enter_hunt = 1'b1; rx_data = 1'b0; sync_in_n = 1'b1;
        @(posedge clk); #1;
        pulses_seen = 0;
        first_seen  = 63;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            enter_hunt = 1'b0;
            rx_data    = v.stream[31-i];
            sync_in_n  = (v.sync_at == 6'(i)) ? 1'b0 : 1'b1;
            @(posedge clk); #1;
            if (!sync_out_n) pulses_seen++;
            if (char_start && first_seen == 63) first_seen = i;
        end
        @(negedge clk);
        sync_in_n = 1'b1;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R10 hunting", 32'(hunting), 1);
        check("R10 char_start", 32'(char_start), 0);
        check("R10 sync_status", 32'(sync_status), 0);
        check("R10 sync_irq", 32'(sync_irq), 0);

        for (int k = 0; k < NV; k++) begin
            run_vec(TBL[k]);
            check($sformatf("R1/R2/R4 pulses vec%0d", k), 32'(pulses_seen), 32'(TBL[k].pulses));
            check($sformatf("R5/R6 first char vec%0d", k), 32'(first_seen), 32'(TBL[k].first_ch));
            check($sformatf("R4/R8 hunting vec%0d", k), 32'(hunting), 32'(TBL[k].hunt_end));
        end

        // R3: output enable by mode
        mode = 2'd1; #1; check("R3 oe mono", 32'(sync_oe), 1);
        mode = 2'd2; #1; check("R3 oe bisync", 32'(sync_oe), 1);
        mode = 2'd3; #1; check("R3 oe ext", 32'(sync_oe), 0);
        check("R3 out idle ext", 32'(sync_out_n), 1);
        mode = 2'd0; #1; check("R3 oe async", 32'(sync_oe), 0);

        // R8/R9: async status and transition pulse
        @(negedge clk) sync_in_n = 1'b0;
        @(posedge clk); #1;
        check("R8 status low input", 32'(sync_status), 1);
        check("R9 irq fall", 32'(sync_irq), 1);
        check("R8 hunting untouched", 32'(hunting), 0);
        @(posedge clk); #1;
        check("R9 irq one cycle", 32'(sync_irq), 0);
        check("R8 status held", 32'(sync_status), 1);
        @(negedge clk) sync_in_n = 1'b1;
        @(posedge clk); #1;
        check("R9 irq rise", 32'(sync_irq), 1);
        check("R8 status high input", 32'(sync_status), 0);
        begin
            int cs = 0;
            for (int i = 0; i < 12; i++) begin
                @(posedge clk); #1;
                if (char_start) cs++;
            end
            check("R8 no char in async", 32'(cs), 0);
        end

        // R7: enter hunt restarts the search and stops strobes
        @(negedge clk);
        mode = 2'd1; sync_pat = 16'h003C; rx_data = 1'b0; enter_hunt = 1'b1;
        @(posedge clk); #1;
        check("R7 hunting set", 32'(hunting), 1);
        @(negedge clk) enter_hunt = 1'b0;
        begin
            int cs = 0;
            for (int i = 0; i < 16; i++) begin
                @(posedge clk); #1;
                if (char_start) cs++;
            end
            check("R7 no char while hunting", 32'(cs), 0);
            check("R7 still hunting", 32'(hunting), 1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule